// File: doc/BRIEF.md
# Host Port Register Access Controller

This block is the port logic on the controlling side of a two-direction buffer. A host drives a select strobe, a 3-bit resource address, a direction bit, a transfer enable and an output enable. On each rising clock edge where the port is selected and enabled, the block does one of three things. It pushes the input word into the outbound FIFO, or it pops the next inbound FIFO word into its output register, or it moves a word through the one-word bypass mailbox in either direction.

The same address space also holds four offset registers that set the almost-empty and almost-full thresholds of the two FIFOs. The host can write these registers, and reading one returns its value through the same 18-bit output register that carries FIFO and mailbox data. The FIFO storage, the mailbox and the flag logic are outside this block and connect through simple request/status ports. The bus pad is modelled as an output word plus a drive-enable, not as a tri-state net.

Top module: `host_port_ctrl`

## Requirements
- R1: While `cs_ni` is high, no request output is raised, the output register and the offset registers do not change, and `drive_o` is low.
- R2: Resource map for `addr_i` with the port selected: 000 is FIFO data, 001 is the bypass mailbox, 100 is the outbound almost-empty offset, 101 is the outbound almost-full offset, 110 is the inbound almost-empty offset, 111 is the inbound almost-full offset. At most one request output is high in any cycle.
- R3: A write (`rw_i`=0, `en_ni`=0, `cs_ni`=0) at 000 raises `ob_wr_req_o` with `ob_wr_data_o`=`data_i` when `ob_full_i` is low. When `ob_full_i` is high the write is dropped and nothing changes.
- R4: A read (`rw_i`=1) at 000 with `ib_empty_i` low raises `ib_rd_req_o`, and after that edge `data_o` holds the `ib_rd_data_i` value. With `ib_empty_i` high there is no pop and `data_o` keeps its value.
- R5: At 001, a write raises `mbx_wr_req_o` if `mbx_full_i` is low (otherwise it is dropped). A read raises `mbx_rd_req_o` and loads `mbx_rd_data_i` into `data_o` if `mbx_empty_i` is low.
- R6: A write at 1xx stores `data_i[8:0]` masked to `DEPTH-1` into the offset selected by `addr_i[1:0]`. With DEPTH=256, bit 8 is stored as 0. A read at 1xx loads that offset into `data_o[8:0]` and zeros into `data_o[17:9]`.
- R7: With `en_ni` high, `data_o` and the offsets keep their values and no request is raised, whatever the address.
- R8: `drive_o` is high only when `oe_ni`=0, `cs_ni`=0 and `rw_i`=1. After an edge that performs a qualified write, `drive_o` stays low until an edge samples `cs_ni`=0 with `rw_i`=1.
- R9: While `rst_ni` is low, all four offsets are 8, `data_o` is 0, and the bus direction state allows driving.
- R10: Addresses 010 and 011 are unmapped. Reads and writes there change nothing and raise no request.
- R11: The four offset outputs always show the stored offset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Port select, active low |
| addr_i | input | 3 | Resource address |
| rw_i | input | 1 | 1 = read, 0 = write |
| en_ni | input | 1 | Transfer enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| data_i | input | DATA_W | Write data from host |
| data_o | output | DATA_W | Output register |
| drive_o | output | 1 | Bus drive enable |
| ob_wr_req_o | output | 1 | Outbound FIFO push |
| ob_wr_data_o | output | DATA_W | Outbound push data |
| ob_full_i | input | 1 | Outbound FIFO full |
| ib_rd_req_o | output | 1 | Inbound FIFO pop |
| ib_rd_data_i | input | DATA_W | Inbound head word |
| ib_empty_i | input | 1 | Inbound FIFO empty |
| mbx_sel_o | output | 1 | Bypass mailbox selected |
| mbx_wr_req_o | output | 1 | Mailbox write |
| mbx_wr_data_o | output | DATA_W | Mailbox write data |
| mbx_full_i | input | 1 | Outgoing mailbox occupied |
| mbx_rd_req_o | output | 1 | Mailbox read |
| mbx_rd_data_i | input | DATA_W | Incoming mailbox word |
| mbx_empty_i | input | 1 | Incoming mailbox empty |
| ob_ae_off_o | output | OFF_W | Outbound almost-empty offset |
| ob_af_off_o | output | OFF_W | Outbound almost-full offset |
| ib_ae_off_o | output | OFF_W | Inbound almost-empty offset |
| ib_af_off_o | output | OFF_W | Inbound almost-full offset |

## Verification
The bench builds the block with DEPTH=256, DATA_W=18 and OFF_W=9. With a depth below 2**OFF_W, the mask on bit 8 is active, so an offset written with bit 8 set must read back with that bit cleared. The outbound queue in the bench is capped at four words, so a short run reaches the full condition and can show the dropped write. The inbound queue runs empty after three pops, which exercises the held-output case.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic [1:0] {
    RES_FIFO = 2'd0,
    RES_BYP  = 2'd1,
    RES_OFF  = 2'd2,
    RES_NONE = 2'd3
  } res_e;

  typedef struct packed {
    logic       wr;
    logic       rd;
    res_e       res;
    logic [1:0] idx;
  } acc_t;
endpackage

// File: rtl/hpc_decode.sv
module hpc_decode
  import hpc_pkg::*;
(
  input  logic       cs_ni,
  input  logic       en_ni,
  input  logic       rw_i,
  input  logic [2:0] addr_i,
  output acc_t       acc_o
);
  logic act;
  assign act = ~cs_ni & ~en_ni;

  always_comb begin
    acc_o.wr  = act & ~rw_i;
    acc_o.rd  = act & rw_i;
    acc_o.idx = addr_i[1:0];
    if (addr_i[2])               acc_o.res = RES_OFF;
    else if (addr_i[1])          acc_o.res = RES_NONE;
    else if (addr_i[0])          acc_o.res = RES_BYP;
    else                         acc_o.res = RES_FIFO;
  end
endmodule

// File: rtl/hpc_offset_regs.sv
module hpc_offset_regs #(
  parameter int OFF_W   = 9,
  parameter int NUM     = 4,
  parameter int DEPTH   = 512,
  parameter int RST_VAL = 8,
  localparam int IDX_W  = $clog2(NUM)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [OFF_W-1:0]     wdata_i,
  output logic [NUM*OFF_W-1:0] off_o
);
  localparam logic [OFF_W-1:0] MASK = OFF_W'(DEPTH - 1);
  localparam logic [OFF_W-1:0] RST  = OFF_W'(RST_VAL);

  for (genvar g = 0; g < NUM; g++) begin : g_off
    logic [OFF_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= RST;
      else if (wr_i && idx_i == IDX_W'(g))   q <= wdata_i & MASK;
    end
    assign off_o[g*OFF_W +: OFF_W] = q;
  end
endmodule

// File: rtl/hpc_bus_drive.sv
module hpc_bus_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic en_ni,
  input  logic rw_i,
  input  logic oe_ni,
  output logic drive_o
);
  logic dir_q;  // 1: port may face outward

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     dir_q <= 1'b1;
    else if (!cs_ni && !en_ni && !rw_i) dir_q <= 1'b0;
    else if (!cs_ni && rw_i)         dir_q <= 1'b1;
  end

  assign drive_o = ~cs_ni & ~oe_ni & rw_i & dir_q;
endmodule

// File: rtl/host_port_ctrl.sv
module host_port_ctrl
  import hpc_pkg::*;
#(
  parameter int DATA_W  = 18,
  parameter int OFF_W   = 9,
  parameter int DEPTH   = 512,
  parameter int OFF_RST = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [2:0]        addr_i,
  input  logic              rw_i,
  input  logic              en_ni,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o,
  output logic              ob_wr_req_o,
  output logic [DATA_W-1:0] ob_wr_data_o,
  input  logic              ob_full_i,
  output logic              ib_rd_req_o,
  input  logic [DATA_W-1:0] ib_rd_data_i,
  input  logic              ib_empty_i,
  output logic              mbx_sel_o,
  output logic              mbx_wr_req_o,
  output logic [DATA_W-1:0] mbx_wr_data_o,
  input  logic              mbx_full_i,
  output logic              mbx_rd_req_o,
  input  logic [DATA_W-1:0] mbx_rd_data_i,
  input  logic              mbx_empty_i,
  output logic [OFF_W-1:0]  ob_ae_off_o,
  output logic [OFF_W-1:0]  ob_af_off_o,
  output logic [OFF_W-1:0]  ib_ae_off_o,
  output logic [OFF_W-1:0]  ib_af_off_o
);
  localparam int NUM_OFF = 4;

  acc_t                     acc;
  logic [NUM_OFF*OFF_W-1:0] off_flat;
  logic [OFF_W-1:0]         off_sel;
  logic                     off_wr, off_rd;
  logic [DATA_W-1:0]        data_q;

  hpc_decode u_dec (
    .cs_ni  (cs_ni),
    .en_ni  (en_ni),
    .rw_i   (rw_i),
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  assign ob_wr_req_o   = acc.wr & (acc.res == RES_FIFO) & ~ob_full_i;
  assign ob_wr_data_o  = data_i;
  assign ib_rd_req_o   = acc.rd & (acc.res == RES_FIFO) & ~ib_empty_i;
  assign mbx_sel_o     = ~cs_ni & (addr_i == 3'b001);
  assign mbx_wr_req_o  = acc.wr & (acc.res == RES_BYP) & ~mbx_full_i;
  assign mbx_wr_data_o = data_i;
  assign mbx_rd_req_o  = acc.rd & (acc.res == RES_BYP) & ~mbx_empty_i;
  assign off_wr        = acc.wr & (acc.res == RES_OFF);
  assign off_rd        = acc.rd & (acc.res == RES_OFF);

  hpc_offset_regs #(
    .OFF_W   (OFF_W),
    .NUM     (NUM_OFF),
    .DEPTH   (DEPTH),
    .RST_VAL (OFF_RST)
  ) u_off (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (off_wr),
    .idx_i   (acc.idx),
    .wdata_i (data_i[OFF_W-1:0]),
    .off_o   (off_flat)
  );

  assign off_sel = off_flat[acc.idx*OFF_W +: OFF_W];

  // shared output register: FIFO, mailbox and offset readback
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           data_q <= '0;
    else if (ib_rd_req_o)  data_q <= ib_rd_data_i;
    else if (mbx_rd_req_o) data_q <= mbx_rd_data_i;
    else if (off_rd)       data_q <= DATA_W'(off_sel);
  end
  assign data_o = data_q;

  hpc_bus_drive u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_ni),
    .en_ni   (en_ni),
    .rw_i    (rw_i),
    .oe_ni   (oe_ni),
    .drive_o (drive_o)
  );

  assign ob_ae_off_o = off_flat[0*OFF_W +: OFF_W];
  assign ob_af_off_o = off_flat[1*OFF_W +: OFF_W];
  assign ib_ae_off_o = off_flat[2*OFF_W +: OFF_W];
  assign ib_af_off_o = off_flat[3*OFF_W +: OFF_W];
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker #(
  parameter int DATA_W = 18,
  parameter int OFF_W  = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic [2:0]        addr_i,
  input logic              rw_i,
  input logic              en_ni,
  input logic              oe_ni,
  input logic [DATA_W-1:0] data_o,
  input logic              drive_o,
  input logic              ob_wr_req_o,
  input logic              ob_full_i,
  input logic              ib_rd_req_o,
  input logic [DATA_W-1:0] ib_rd_data_i,
  input logic              ib_empty_i,
  input logic              mbx_wr_req_o,
  input logic              mbx_rd_req_o
);
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !(ob_wr_req_o || ib_rd_req_o || mbx_wr_req_o || mbx_rd_req_o || drive_o));

  assert_one_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ob_wr_req_o, ib_rd_req_o, mbx_wr_req_o, mbx_rd_req_o}));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ob_full_i |-> !ob_wr_req_o);

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_empty_i |-> !ib_rd_req_o);

  assert_pop_loads_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ib_rd_req_o |=> data_o == $past(ib_rd_data_i));

  assert_off_upper_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !en_ni && rw_i && addr_i[2]) |=> data_o[DATA_W-1:OFF_W] == '0);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ni || cs_ni) |=> $stable(data_o));

  assert_drive_cond_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> (!oe_ni && !cs_ni && rw_i));

  assert_write_hiz_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !en_ni && !rw_i) |=> !drive_o);
endmodule

bind host_port_ctrl hpc_checker #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_ni        (cs_ni),
  .addr_i       (addr_i),
  .rw_i         (rw_i),
  .en_ni        (en_ni),
  .oe_ni        (oe_ni),
  .data_o       (data_o),
  .drive_o      (drive_o),
  .ob_wr_req_o  (ob_wr_req_o),
  .ob_full_i    (ob_full_i),
  .ib_rd_req_o  (ib_rd_req_o),
  .ib_rd_data_i (ib_rd_data_i),
  .ib_empty_i   (ib_empty_i),
  .mbx_wr_req_o (mbx_wr_req_o),
  .mbx_rd_req_o (mbx_rd_req_o)
);

// File: tb/sim_host_port_ctrl.sv
module sim_host_port_ctrl;
  localparam int DATA_W = 18;
  localparam int OFF_W  = 9;
  localparam int DEPTH  = 256;
  localparam int OB_CAP = 4;
  localparam logic [OFF_W-1:0] MASK = OFF_W'(DEPTH - 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, rw_i = 1'b1, en_ni = 1'b1, oe_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic [DATA_W-1:0] data_o, ob_wr_data_o, mbx_wr_data_o;
  logic drive_o, ob_wr_req_o, ib_rd_req_o, mbx_sel_o, mbx_wr_req_o, mbx_rd_req_o;
  logic ob_full_i = 1'b0, ib_empty_i = 1'b1, mbx_full_i = 1'b0, mbx_empty_i = 1'b1;
  logic [DATA_W-1:0] ib_rd_data_i = '0, mbx_rd_data_i = '0;
  logic [OFF_W-1:0] ob_ae_off_o, ob_af_off_o, ib_ae_off_o, ib_af_off_o;

  always #5 clk_i = ~clk_i;

  host_port_ctrl #(.DATA_W(DATA_W), .OFF_W(OFF_W), .DEPTH(DEPTH), .OFF_RST(8)) u0 (.*);

  int vectors = 0, miscompares = 0;
  logic [DATA_W-1:0] obq[$], ibq[$], mab[$], mba[$];
  logic [DATA_W-1:0] exp_out;
  logic [OFF_W-1:0]  exp_off[4];
  bit exp_dir;

  task automatic chk(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic refresh();
    ob_full_i     = obq.size() >= OB_CAP;
    ib_empty_i    = ibq.size() == 0;
    ib_rd_data_i  = ib_empty_i ? '0 : ibq[0];
    mbx_full_i    = mab.size() >= 1;
    mbx_empty_i   = mba.size() == 0;
    mbx_rd_data_i = mbx_empty_i ? '0 : mba[0];
  endtask

  // model of the edge just passed, using inputs that were held across it
  task automatic step(string tag);
    bit act, e_obw, e_ibr, e_mw, e_mr, e_drv;
    act = !cs_ni && !en_ni;
    e_obw = 0; e_ibr = 0; e_mw = 0; e_mr = 0;
    if (act && !rw_i) begin
      if (addr_i == 3'd0) e_obw = !ob_full_i;
      else if (addr_i == 3'd1) e_mw = !mbx_full_i;
      else if (addr_i[2]) exp_off[addr_i[1:0]] = data_i[OFF_W-1:0] & MASK;
    end
    if (act && rw_i) begin
      if (addr_i == 3'd0 && !ib_empty_i) begin e_ibr = 1; exp_out = ib_rd_data_i; end
      else if (addr_i == 3'd1 && !mbx_empty_i) begin e_mr = 1; exp_out = mbx_rd_data_i; end
      else if (addr_i[2]) exp_out = DATA_W'(exp_off[addr_i[1:0]]);
    end
    if (act && !rw_i) exp_dir = 0;
    else if (!cs_ni && rw_i) exp_dir = 1;
    chk(tag, "ob_wr_req", DATA_W'(ob_wr_req_o), DATA_W'(e_obw));
    chk(tag, "ib_rd_req", DATA_W'(ib_rd_req_o), DATA_W'(e_ibr));
    chk(tag, "mbx_wr_req", DATA_W'(mbx_wr_req_o), DATA_W'(e_mw));
    chk(tag, "mbx_rd_req", DATA_W'(mbx_rd_req_o), DATA_W'(e_mr));
    if (e_obw) chk(tag, "ob_wr_data", ob_wr_data_o, data_i);
    if (e_mw)  chk(tag, "mbx_wr_data", mbx_wr_data_o, data_i);
    if (ob_wr_req_o)  obq.push_back(ob_wr_data_o);
    if (ib_rd_req_o && ibq.size() > 0) void'(ibq.pop_front());
    if (mbx_wr_req_o) mab.push_back(mbx_wr_data_o);
    if (mbx_rd_req_o && mba.size() > 0) void'(mba.pop_front());
    refresh();
    e_drv = !cs_ni && !oe_ni && rw_i && exp_dir;
    chk(tag, "data_o", data_o, exp_out);
    chk(tag, "drive_o", DATA_W'(drive_o), DATA_W'(e_drv));
    chk("R11", "offsets", DATA_W'({ob_ae_off_o, ob_af_off_o}), DATA_W'({exp_off[0], exp_off[1]}));
    chk("R11", "offsets", DATA_W'({ib_ae_off_o, ib_af_off_o}), DATA_W'({exp_off[2], exp_off[3]}));
  endtask

  task automatic tick(string tag, bit cs, bit [2:0] a, bit rw, bit en, bit oe, logic [DATA_W-1:0] d);
    cs_ni = cs; addr_i = a; rw_i = rw; en_ni = en; oe_ni = oe; data_i = d;
    @(negedge clk_i);
    step(tag);
  endtask

  bit done = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #100000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_off[i] = 9'd8;
    exp_out = '0; exp_dir = 1;
    refresh();
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk("R9", "data_o", data_o, '0);
    chk("R9", "off", DATA_W'(ob_ae_off_o), 18'd8);
    chk("R9", "off", DATA_W'(ib_af_off_o), 18'd8);
    chk("R1", "drive_o", DATA_W'(drive_o), '0);
    rst_ni = 1'b1;
    // R9 R6 offsets read back as 8 through output register
    for (int a = 4; a < 8; a++) tick("R9", 0, 3'(a), 1, 0, 0, '0);
    // R6 writes with junk upper bits and bit 8 set
    tick("R6", 0, 3'd4, 0, 0, 0, 18'h3FFF3);
    tick("R6", 0, 3'd5, 0, 0, 0, 18'h00105);
    tick("R6", 0, 3'd6, 0, 0, 0, 18'h2A0C0);
    tick("R6", 0, 3'd7, 0, 0, 0, 18'h0007F);
    for (int a = 4; a < 8; a++) tick("R6", 0, 3'(a), 1, 0, 0, '0);
    // R8 write leaves bus undriven until rw high sampled
    tick("R8", 0, 3'd0, 0, 0, 0, 18'h11111);
    tick("R8", 0, 3'd4, 1, 1, 0, '0);
    tick("R8", 0, 3'd4, 1, 1, 0, '0);
    tick("R8", 0, 3'd4, 1, 1, 1, '0);
    // R3 fill outbound to full, then drop
    for (int i = 0; i < 5; i++) tick("R3", 0, 3'd0, 0, 0, 0, 18'(18'h20000 + i));
    chk("R3", "ob count", DATA_W'(obq.size()), DATA_W'(OB_CAP));
    chk("R3", "ob first", obq[0], 18'h11111);
    chk("R3", "ob last", obq[OB_CAP-1], 18'h20002);
    obq.delete(); refresh();
    tick("R3", 0, 3'd0, 0, 0, 0, 18'h0ABCD);
    // R4 inbound reads until empty
    ibq.push_back(18'h1A5A5); ibq.push_back(18'h2C3C3); ibq.push_back(18'h00F0F); refresh();
    tick("R7", 0, 3'd0, 1, 1, 0, '0);
    for (int i = 0; i < 4; i++) tick("R4", 0, 3'd0, 1, 0, 0, '0);
    // R7 enable high at every address
    for (int a = 0; a < 8; a++) tick("R7", 0, 3'(a), 0, 1, 0, 18'h3FFFF);
    // R1 deselected
    ibq.push_back(18'h12345); refresh();
    tick("R1", 1, 3'd0, 1, 0, 0, '0);
    tick("R1", 1, 3'd0, 0, 0, 0, 18'h3C3C3);
    tick("R1", 1, 3'd5, 0, 0, 0, 18'h00011);
    tick("R4", 0, 3'd0, 1, 0, 0, '0);
    // R10 unmapped
    tick("R10", 0, 3'd2, 0, 0, 0, 18'h00033);
    tick("R10", 0, 3'd3, 1, 0, 0, '0);
    tick("R10", 0, 3'd2, 1, 0, 0, '0);
    // R5 bypass both ways
    tick("R5", 0, 3'd1, 0, 0, 0, 18'h2BEEF);
    tick("R5", 0, 3'd1, 0, 0, 0, 18'h3DEAD);
    chk("R5", "mbx word", mab.size() > 0 ? mab[0] : '0, 18'h2BEEF);
    chk("R5", "mbx sel", DATA_W'(mbx_sel_o), 18'd1);
    tick("R5", 0, 3'd1, 1, 0, 0, '0);
    mba.push_back(18'h15A5A); refresh();
    tick("R5", 0, 3'd1, 1, 0, 0, '0);
    tick("R5", 0, 3'd1, 1, 0, 0, '0);
    // R2 offset read after traffic
    tick("R2", 0, 3'd6, 1, 0, 0, '0);
    done = 1;
    summary();
    $finish;
  end
endmodule